// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synchronous, cycle-based model of a 1024-bit serial EEPROM that a host reaches over three wires: chip select, shift clock and serial data in. A fourth pin returns serial data out, together with an output-enable that stands in for a tri-state driver. All three host inputs and the organisation pin pass through a synchroniser into the system clock domain. Every shift-clock rising edge is found in that domain, and the serial data is sampled on it.

An instruction starts with a 1 start bit, while chip select is high. A two-bit opcode follows, then an address field. Its length depends on the organisation pin: 16-bit words at 64 locations, or bytes at 128 locations. Programming instructions start a self-timed cycle whose length, in system clocks, is a parameter. A write-enable latch, cleared at reset, must be set before any programming instruction has an effect. The host can poll a ready/busy flag on data out by raising chip select again after a programming instruction.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high, 0 bits that arrive before the first 1 are ignored. That 1 is the start bit. It is followed by a 2-bit opcode and the address, each sent MSB first.
- R2: When the organisation input is 1 (word mode), the address is 6 bits and data is 16 bits. When it is 0 (byte mode), the address is 7 bits and data is 8 bits. Byte address b maps onto word b>>1: its upper half when b[0]=1, its lower half when b[0]=0.
- R3: Opcode 10 reads. After the last address bit, data out is driven to 0 as a dummy bit. The stored value then follows MSB first, one bit per further shift-clock rising edge.
- R4: Opcode 01 writes the data bits that follow the address into the addressed location. No erase is needed beforehand.
- R5: After reset, programming is disabled and every memory bit is 1. Opcode 00 with sub-code 11 in the top two address bits enables programming. Sub-code 00 disables it. The enable persists across instructions.
- R6: While programming is disabled, write, erase, write-all and erase-all change nothing and start no busy cycle. Read works in either state.
- R7: Opcode 11 sets the addressed location to all ones. Opcode 00 with sub-code 10 sets the whole array to all ones.
- R8: Opcode 00 with sub-code 01 takes a data field and writes it into every location.
- R9: A programming instruction keeps the block busy for PROG_CYCLES system clocks. If chip select is raised while the block is busy, data out is enabled and shows 0 while busy and 1 once done, until chip select falls.
- R10: An instruction clocked in while the block is busy is ignored.
- R11: Dropping chip select before an instruction is complete aborts it, with no change to memory and no busy cycle.
- R12: Data out is disabled whenever chip select is low, and while idle with no read or status pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Serial data out drive enable |

## Verification
The bench builds the block with PROG_CYCLES set to 600 and two synchroniser stages. This busy window is long enough to clock a complete instruction into the block while it is still busy, which exercises the ignore rule. It is also short enough to run every programming form in both organisations. The shift clock runs at twelve system clocks per bit, so the synchroniser delay fits inside one half period. Data out can therefore be sampled at a fixed point late in each low phase.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int ARR_WORDS = 64;
    localparam int WORD_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int WADDR_W   = $clog2(ARR_WORDS);
    localparam int BADDR_W   = WADDR_W + 1;
    localparam int OP_W      = 2;
    localparam int HDR_W     = OP_W + BADDR_W;
    localparam int CNT_W     = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {
        K_NONE, K_READ, K_WRITE, K_ERASE, K_ERAL, K_WRAL, K_EWEN, K_EWDS
    } cmd_kind_t;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_DATA, S_READ, S_HOLD
    } seq_state_t;

    typedef struct packed {
        cmd_kind_t          kind;
        logic [BADDR_W-1:0] addr;
    } cmd_t;

    function automatic int hdr_len(input logic word_mode);
        return word_mode ? OP_W + WADDR_W : OP_W + BADDR_W;
    endfunction

    function automatic int data_len(input logic word_mode);
        return word_mode ? WORD_W : BYTE_W;
    endfunction

    function automatic cmd_t decode_hdr(input logic [HDR_W-1:0] h, input logic word_mode);
        cmd_t       c;
        logic [1:0] op;
        logic [1:0] sub;
        if (word_mode) begin
            op     = h[WADDR_W+1:WADDR_W];
            sub    = h[WADDR_W-1:WADDR_W-2];
            c.addr = {1'b0, h[WADDR_W-1:0]};
        end else begin
            op     = h[BADDR_W+1:BADDR_W];
            sub    = h[BADDR_W-1:BADDR_W-2];
            c.addr = h[BADDR_W-1:0];
        end
        case (op)
            2'b10:   c.kind = K_READ;
            2'b01:   c.kind = K_WRITE;
            2'b11:   c.kind = K_ERASE;
            default: begin
                case (sub)
                    2'b11:   c.kind = K_EWEN;
                    2'b10:   c.kind = K_ERAL;
                    2'b01:   c.kind = K_WRAL;
                    default: c.kind = K_EWDS;
                endcase
            end
        endcase
        return c;
    endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CW'(CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    // R10: a new cycle is never requested while one is running
    a_r10_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R9: the countdown stays inside its window
    a_r9_count_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(cnt) < CYCLES));
    // R9: completion releases busy on the next clock
    a_r9_done_release: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               word_mode,
    input  logic               we,
    input  cmd_kind_t          wr_kind,
    input  logic [BADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [BADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0]  rd_data
);
    logic [ARR_WORDS-1:0][WORD_W-1:0] words;

    for (genvar w = 0; w < ARR_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit;
        logic [WORD_W-1:0] val;

        assign hit = word_mode ? (int'(wr_addr[WADDR_W-1:0]) == w)
                               : (int'(wr_addr[BADDR_W-1:1]) == w);
        assign val = (wr_kind == K_ERASE) ? '1 : wr_data;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '1;
            end else if (we) begin
                case (wr_kind)
                    K_ERAL: word_q <= '1;
                    K_WRAL: word_q <= word_mode ? wr_data : {2{wr_data[BYTE_W-1:0]}};
                    K_ERASE, K_WRITE: begin
                        if (hit) begin
                            if (word_mode)       word_q               <= val;
                            else if (wr_addr[0]) word_q[WORD_W-1:BYTE_W] <= val[BYTE_W-1:0];
                            else                 word_q[BYTE_W-1:0]   <= val[BYTE_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
        assign words[w] = word_q;
    end

    always_comb begin
        if (word_mode) rd_data = words[rd_addr[WADDR_W-1:0]];
        else if (rd_addr[0])
            rd_data = {words[rd_addr[BADDR_W-1:1]][WORD_W-1:BYTE_W], {BYTE_W{1'b0}}};
        else
            rd_data = {words[rd_addr[BADDR_W-1:1]][BYTE_W-1:0], {BYTE_W{1'b0}}};
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    input  logic org_i,
    output logic do_o,
    output logic do_oe_o
);
    logic cs_s, sk_s, di_s, org_s;
    logic sk_q, cs_q;
    logic sk_rise, cs_rise;

    mw_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .d({cs_i, sk_i, di_i, org_i}),
        .q({cs_s, sk_s, di_s, org_s})
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk_s;
            cs_q <= cs_s;
        end
    end
    assign sk_rise = sk_s & ~sk_q;
    assign cs_rise = cs_s & ~cs_q;

    seq_state_t         state;
    logic [HDR_W-1:0]   hdr;
    logic [HDR_W-1:0]   nh;
    logic [CNT_W-1:0]   cnt;
    cmd_t               cmd_q;
    cmd_t               dec;
    logic [WORD_W-1:0]  data_q;
    logic [WORD_W:0]    rd_sr;
    logic [WORD_W-1:0]  rd_data;
    logic               mode_q;
    logic               wen;
    logic               stat_en;
    logic               prog_go;
    logic               busy;
    logic               done;

    assign nh  = {hdr[HDR_W-2:0], di_s};
    assign dec = decode_hdr(nh, mode_q);

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(prog_go), .busy(busy), .done(done)
    );

    mw_array u_array (
        .clk(clk), .rst(rst), .word_mode(mode_q),
        .we(done), .wr_kind(cmd_q.kind), .wr_addr(cmd_q.addr), .wr_data(data_q),
        .rd_addr(dec.addr), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            hdr     <= '0;
            cnt     <= '0;
            cmd_q   <= '{kind: K_NONE, addr: '0};
            data_q  <= '0;
            rd_sr   <= '0;
            mode_q  <= 1'b1;
            wen     <= 1'b0;
            prog_go <= 1'b0;
        end else begin
            prog_go <= 1'b0;
            if (!cs_s) begin
                state <= S_IDLE;
            end else if (sk_rise) begin
                case (state)
                    S_IDLE: begin
                        if (di_s && !busy) begin
                            state  <= S_HDR;
                            hdr    <= '0;
                            cnt    <= '0;
                            mode_q <= org_s;
                        end
                    end
                    S_HDR: begin
                        hdr <= nh;
                        cnt <= cnt + 1'b1;
                        if (int'(cnt) == hdr_len(mode_q) - 1) begin
                            cmd_q  <= dec;
                            cnt    <= '0;
                            data_q <= '0;
                            state  <= S_HOLD;
                            case (dec.kind)
                                K_READ: begin
                                    state <= S_READ;
                                    rd_sr <= {1'b0, rd_data};
                                end
                                K_WRITE, K_WRAL: state <= S_DATA;
                                K_ERASE, K_ERAL: prog_go <= wen;
                                K_EWEN:          wen <= 1'b1;
                                K_EWDS:          wen <= 1'b0;
                                default: ;
                            endcase
                        end
                    end
                    S_DATA: begin
                        data_q <= {data_q[WORD_W-2:0], di_s};
                        cnt    <= cnt + 1'b1;
                        if (int'(cnt) == data_len(mode_q) - 1) begin
                            prog_go <= wen;
                            state   <= S_HOLD;
                        end
                    end
                    S_READ:  rd_sr <= {rd_sr[WORD_W-1:0], 1'b0};
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 stat_en <= 1'b0;
        else if (!cs_s)          stat_en <= 1'b0;
        else if (cs_rise && busy) stat_en <= 1'b1;
    end

    assign do_oe_o = cs_s && ((state == S_READ) || stat_en);
    assign do_o    = (state == S_READ) ? rd_sr[WORD_W] : !busy;

    // R5: programming starts disabled after reset
    a_r5_reset_disabled: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wen);
    // R6: no programming cycle is launched without the enable latch
    a_r6_gated_start: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> wen);
    // R3: the first driven read bit is the dummy zero
    a_r3_dummy_zero: assert property (@(posedge clk) disable iff (rst)
        (state == S_READ && $past(state) != S_READ) |-> (do_o == 1'b0));
    // R10: while busy, an idle sequencer does not accept a start bit
    a_r10_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && state == S_IDLE) |=> (state == S_IDLE));
endmodule

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
    localparam int PC = 600;
    localparam int H  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic dout, doe;

    int checks = 0;
    int errors = 0;
    bit wm = 1'b1;
    bit wen_m = 1'b0;
    logic [7:0] m [128];

    always #2 clk = ~clk;

    mw_eeprom #(.PROG_CYCLES(PC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
        .do_o(dout), .do_oe_o(doe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int alen();
        return wm ? 6 : 7;
    endfunction

    function automatic int dlen();
        return wm ? 16 : 8;
    endfunction

    function automatic logic [1:0] sub_of(input logic [6:0] a);
        return wm ? a[5:4] : a[6:5];
    endfunction

    function automatic logic [6:0] spec_addr(input logic [1:0] s);
        return wm ? {1'b0, s, 4'b0} : {s, 5'b0};
    endfunction

    function automatic logic [15:0] model_read(input logic [6:0] a);
        if (wm) return {m[{a[5:0], 1'b1}], m[{a[5:0], 1'b0}]};
        return {8'h00, m[a]};
    endfunction

    task automatic model_write(input logic [6:0] a, input logic [15:0] d);
        if (wm) begin
            m[{a[5:0], 1'b0}] = d[7:0];
            m[{a[5:0], 1'b1}] = d[15:8];
        end else m[a] = d[7:0];
    endtask

    task automatic set_mode(input bit w);
        wm = w;
        org = w;
        wait_clk(H);
    endtask

    task automatic put_bit(input logic b);
        di = b;
        wait_clk(H);
        sk = 1'b1;
        wait_clk(H);
        sk = 1'b0;
    endtask

    task automatic begin_cmd();
        cs = 1'b1;
        wait_clk(H);
    endtask

    task automatic end_cmd();
        wait_clk(H);
        di = 1'b0;
        cs = 1'b0;
        wait_clk(H);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [6:0] a);
        put_bit(1'b1);
        put_bit(op[1]);
        put_bit(op[0]);
        for (int i = alen() - 1; i >= 0; i--) put_bit(a[i]);
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = dlen() - 1; i >= 0; i--) put_bit(d[i]);
    endtask

    task automatic rd(input logic [6:0] a, input int lead, input string tag);
        logic [15:0] got;
        logic [15:0] exp;
        got = '0;
        begin_cmd();
        repeat (lead) put_bit(1'b0);
        send_hdr(2'b10, a);
        wait_clk(H);
        chk(doe === 1'b1 && dout === 1'b0, "R3 dummy bit", {doe, dout}, 2'b10);
        for (int i = 0; i < dlen(); i++) begin
            sk = 1'b1;
            wait_clk(H);
            sk = 1'b0;
            wait_clk(H);
            got = {got[14:0], dout};
        end
        exp = model_read(a);
        chk(got == exp, tag, got, exp);
        end_cmd();
    endtask

    task automatic prog(input logic [1:0] op, input logic [6:0] a, input logic [15:0] d, input string tag);
        logic [1:0] s;
        bit has_data;
        bit is_prog;
        s = sub_of(a);
        has_data = (op == 2'b01) || (op == 2'b00 && s == 2'b01);
        is_prog = (op == 2'b01) || (op == 2'b11) || (op == 2'b00 && (s == 2'b01 || s == 2'b10));
        begin_cmd();
        send_hdr(op, a);
        if (has_data) send_data(d);
        end_cmd();
        if (is_prog) begin
            cs = 1'b1;
            wait_clk(H);
            if (wen_m) begin
                chk(doe === 1'b1 && dout === 1'b0, {tag, " R9 busy"}, {doe, dout}, 2'b10);
                wait_clk(PC);
                chk(doe === 1'b1 && dout === 1'b1, {tag, " R9 ready"}, {doe, dout}, 2'b11);
            end else begin
                chk(doe === 1'b0, {tag, " R6 no busy cycle"}, doe, 0);
            end
            end_cmd();
        end
        if (op == 2'b00) begin
            case (s)
                2'b11: wen_m = 1'b1;
                2'b00: wen_m = 1'b0;
                2'b10: if (wen_m) for (int i = 0; i < 128; i++) m[i] = 8'hFF;
                default: if (wen_m) for (int i = 0; i < 128; i++)
                    m[i] = wm ? (i[0] ? d[15:8] : d[7:0]) : d[7:0];
            endcase
        end else if (wen_m) begin
            if (op == 2'b01) model_write(a, d);
            else if (op == 2'b11) model_write(a, 16'hFFFF);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m[i] = 8'hFF;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(H);
        chk(doe === 1'b0, "R12 reset drive off", doe, 0);
        cs = 1'b1;
        wait_clk(H);
        chk(doe === 1'b0, "R12 idle select drive off", doe, 0);
        cs = 1'b0;
        wait_clk(H);

        rd(7'd5, 0, "R5 erased after reset");
        prog(2'b01, 7'd5, 16'h1234, "R6 write while disabled");
        rd(7'd5, 0, "R6 disabled write kept old");

        prog(2'b00, spec_addr(2'b11), 16'h0, "R5 enable");
        prog(2'b01, 7'd5, 16'hA5C3, "R4 write");
        rd(7'd5, 0, "R3 R4 read back word");

        set_mode(1'b0);
        rd(7'd10, 0, "R2 low byte of word 5");
        rd(7'd11, 0, "R2 high byte of word 5");
        prog(2'b01, 7'd11, 16'h005A, "R4 byte write");
        set_mode(1'b1);
        rd(7'd5, 0, "R2 word after byte write");

        // R10: instruction during busy is ignored
        begin_cmd();
        send_hdr(2'b01, 7'd7);
        send_data(16'h1111);
        end_cmd();
        cs = 1'b1;
        wait_clk(H);
        chk(doe === 1'b1 && dout === 1'b0, "R9 busy before intrusion", {doe, dout}, 2'b10);
        send_hdr(2'b01, 7'd8);
        send_data(16'h2222);
        chk(doe === 1'b1 && dout === 1'b0, "R10 still busy", {doe, dout}, 2'b10);
        wait_clk(PC);
        chk(doe === 1'b1 && dout === 1'b1, "R10 ready", {doe, dout}, 2'b11);
        end_cmd();
        model_write(7'd7, 16'h1111);
        rd(7'd8, 0, "R10 ignored write left location");
        rd(7'd7, 0, "R10 first write stored");

        // R11: aborted write
        begin_cmd();
        send_hdr(2'b01, 7'd7);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        end_cmd();
        cs = 1'b1;
        wait_clk(H);
        chk(doe === 1'b0, "R11 no busy after abort", doe, 0);
        end_cmd();
        rd(7'd7, 0, "R11 aborted write kept data");

        prog(2'b11, 7'd5, 16'h0, "R7 erase word");
        rd(7'd5, 0, "R7 erased word");
        set_mode(1'b0);
        prog(2'b11, 7'd14, 16'h0, "R7 erase byte");
        set_mode(1'b1);
        rd(7'd7, 0, "R7 byte erase only low half");

        prog(2'b00, spec_addr(2'b01), 16'h0F0F, "R8 write all word");
        rd(7'd0, 0, "R8 word 0");
        rd(7'd63, 0, "R8 word 63");
        set_mode(1'b0);
        prog(2'b00, spec_addr(2'b01), 16'h003C, "R8 write all byte");
        rd(7'd127, 0, "R8 byte 127");
        set_mode(1'b1);
        rd(7'd20, 0, "R8 word after byte fill");

        prog(2'b00, spec_addr(2'b10), 16'h0, "R7 erase all");
        rd(7'd33, 0, "R7 erase all word 33");

        prog(2'b01, 7'd3, 16'h0000, "R4 write zero");
        prog(2'b00, spec_addr(2'b00), 16'h0, "R5 disable");
        prog(2'b01, 7'd3, 16'hBEEF, "R6 write after disable");
        prog(2'b00, spec_addr(2'b10), 16'h0, "R6 erase all after disable");
        rd(7'd3, 0, "R6 read works while disabled");
        rd(7'd3, 3, "R1 leading zeros before start");

        // R12: dropping select mid-read releases data out
        begin_cmd();
        send_hdr(2'b10, 7'd3);
        wait_clk(H);
        chk(doe === 1'b1, "R12 driven during read", doe, 1);
        cs = 1'b0;
        wait_clk(H);
        chk(doe === 1'b0, "R12 released after select low", doe, 0);
        wait_clk(H);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule